// File: doc/BRIEF.md
# Vector Element Broadcast Selector

This block prepares the second operand of an eight-lane, 16-bit-per-lane vector datapath. A 128-bit source vector comes in with a small element-select code taken from the instruction. The block builds a new vector in which every output lane is a copy of one source lane. The choice of source lane follows a fixed family of patterns:

- pass-through
- replication inside lane pairs
- replication inside halves of four lanes
- a single lane broadcast to the whole vector

The arithmetic lanes downstream then see the operand already laid out for element-wise use.

The lane swizzle itself is purely combinational. It is followed by one output register with a valid bit, so the block sits in the pipeline as a single stage. The code is first sorted into one of four pattern classes: pass, pair, quad and broadcast. Each output lane then computes its own source index from that class and from the low code bits. There is no sequencing state. The only transitions are the output register's capture, which happens when `in_valid` is high, and its hold, which happens when `in_valid` is low.

Top module: `elem_bcast_sel`

## Requirements
- R1: Only bits [3:0] of `sel_code` take part in the selection. The upper bits of the code have no effect on `out_vec`.
- R2: Codes 0 and 1 pass the source vector through unchanged.
- R3: Code 2 fills output lanes 0..7 from source lanes 0,0,2,2,4,4,6,6.
- R4: Code 3 fills output lanes 0..7 from source lanes 1,1,3,3,5,5,7,7.
- R5: Code 4+k (k = 0..3) fills output lanes 0..3 from source lane k, and output lanes 4..7 from source lane 4+k.
- R6: Code 8+k (k = 0..7) copies source lane k into all eight output lanes.
- R7: Lane n occupies bits [127-16n : 112-16n] of both `src_vec` and `out_vec`, so lane 0 is the most significant 16 bits.
- R8: A value presented with `in_valid` high appears on `out_vec` after the next rising edge. `out_valid` equals the `in_valid` of the previous cycle.
- R9: While `in_valid` is low, `out_vec` keeps its last captured value.
- R10: A synchronous active-high `rst` clears `out_vec` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source vector and code are valid this cycle |
| src_vec | input | 128 | Source vector, lane 0 in the top 16 bits |
| sel_code | input | 5 | Element-select code; only bits [3:0] are used |
| out_vec | output | 128 | Registered swizzled operand |
| out_valid | output | 1 | `out_vec` holds a newly captured result |

## Verification
Every result is due exactly one rising edge after the cycle in which its inputs were presented with `in_valid` high. The driver applies inputs on the falling edge and records the expected vector in a queue. The monitor samples shortly after each rising edge. When `out_valid` is high it pops and compares one entry; when `out_valid` is low it checks that the previous value is still held. At every sample it also compares `out_valid` with the `in_valid` that the edge just captured, so a result that arrives early or late counts as a mismatch in that same cycle.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    // Pattern classes decoded from the element-select code
    typedef enum logic [1:0] {
        PAT_PASS  = 2'd0,
        PAT_PAIR  = 2'd1,
        PAT_QUAD  = 2'd2,
        PAT_BCAST = 2'd3
    } pat_e;

    localparam int unsigned CODE_USED_W = 4;

    function automatic pat_e classify(input logic [CODE_USED_W-1:0] code);
        pat_e p;
        unique casez (code)
            4'b000?: p = PAT_PASS;
            4'b001?: p = PAT_PAIR;
            4'b01??: p = PAT_QUAD;
            4'b1???: p = PAT_BCAST;
            default: p = PAT_PASS;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ebs_lane_map.sv
module ebs_lane_map
    import ebs_pkg::*;
#(
    parameter int unsigned LANES = 8,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic [CODE_USED_W-1:0]           code,
    output logic [LANES-1:0][IDX_W-1:0]      src_idx
);

    pat_e pat;

    always_comb pat = classify(code);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [IDX_W-1:0] LG = IDX_W'(g);
        always_comb begin
            unique case (pat)
                PAT_PASS:  src_idx[g] = LG;
                PAT_PAIR:  src_idx[g] = {LG[IDX_W-1:1], code[0]};
                PAT_QUAD:  src_idx[g] = {LG[IDX_W-1], code[1:0]};
                PAT_BCAST: src_idx[g] = code[IDX_W-1:0];
                default:   src_idx[g] = LG;
            endcase
        end
    end

endmodule

// File: rtl/ebs_lane_mux.sv
module ebs_lane_mux #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][LANE_W-1:0] src,
    input  logic [LANES-1:0][IDX_W-1:0]  src_idx,
    output logic [LANES-1:0][LANE_W-1:0] dst
);

    // Lane n sits at packed slot LANES-1-n (lane 0 is most significant)
    for (genvar g = 0; g < LANES; g++) begin : g_mux
        localparam int unsigned SLOT = LANES - 1 - g;
        always_comb dst[SLOT] = src[(LANES-1) - int'(src_idx[g])];
    end

endmodule

// File: rtl/ebs_out_reg.sv
module ebs_out_reg #(
    parameter int unsigned WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end

endmodule

// File: rtl/elem_bcast_sel.sv
module elem_bcast_sel
    import ebs_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned CODE_W = 5,
    localparam int unsigned VEC_W = LANES * LANE_W,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [CODE_W-1:0] sel_code,
    output logic [VEC_W-1:0]  out_vec,
    output logic              out_valid
);

    logic [CODE_USED_W-1:0]          code_lo;
    logic [LANES-1:0][IDX_W-1:0]     src_idx;
    logic [LANES-1:0][LANE_W-1:0]    swz;

    // R1: upper code bits are dropped here
    assign code_lo = sel_code[CODE_USED_W-1:0];

    ebs_lane_map #(.LANES(LANES)) u_map (
        .code    (code_lo),
        .src_idx (src_idx)
    );

    ebs_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
        .src     (src_vec),
        .src_idx (src_idx),
        .dst     (swz)
    );

    ebs_out_reg #(.WIDTH(VEC_W)) u_oreg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (swz),
        .q       (out_vec),
        .q_valid (out_valid)
    );

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));
    a_r2_identity: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel_code[3:1] == 3'b000) |=> out_vec == $past(src_vec));
    a_r6_all_lanes_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel_code[3]) |=> out_vec == {LANES{out_vec[LANE_W-1:0]}});
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0));

endmodule

// File: tb/tb_elem_bcast_sel.sv
module tb_elem_bcast_sel;

    localparam int LANES = 8;
    localparam int LW    = 16;
    localparam int VW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [4:0]    sel_code = '0;
    logic [VW-1:0] out_vec;
    logic          out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    logic [VW-1:0] exp_q[$];
    logic [VW-1:0] last_exp = '0;
    bit            mon_on = 1'b0;
    bit            done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    elem_bcast_sel dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .sel_code(sel_code), .out_vec(out_vec), .out_valid(out_valid)
    );

    // Lane n at bits [VW-1-LW*n -: LW] (R7)
    function automatic logic [LW-1:0] lane_of(input logic [VW-1:0] v, input int n);
        return v[VW-1-LW*n -: LW];
    endfunction

    function automatic logic [VW-1:0] model(input logic [VW-1:0] s, input logic [4:0] c);
        logic [VW-1:0] r;
        int k;
        int src;
        k = int'(c) % 16;   // R1
        for (int i = 0; i < LANES; i++) begin
            if (k < 2)      src = i;                     // R2
            else if (k < 4) src = 2*(i/2) + (k-2);       // R3, R4
            else if (k < 8) src = 4*(i/4) + (k-4);       // R5
            else            src = k - 8;                 // R6
            r[VW-1-LW*i -: LW] = lane_of(s, src);
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] lane_pattern(input logic [7:0] seed);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++)
            v[VW-1-LW*i -: LW] = {seed, 4'(i), 4'(i) ^ seed[3:0]};
        return v;
    endfunction

    task automatic drive(input logic [VW-1:0] s, input logic [4:0] c, input bit v);
        @(negedge clk);
        src_vec  = s;
        sel_code = c;
        in_valid = v;
        if (v) exp_q.push_back(model(s, c));
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: sample 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (mon_on && !rst) begin
            check(out_valid == in_valid, "R8 out_valid", VW'(out_valid), VW'(in_valid));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", out_vec, '0);
                end else begin
                    last_exp = exp_q.pop_front();
                    check(out_vec == last_exp, "R2-R7 data", out_vec, last_exp);
                end
            end else begin
                check(out_vec == last_exp, "R9 hold", out_vec, last_exp);
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_vec == '0 && out_valid == 1'b0, "R10 reset", out_vec, '0);
        rst = 1'b0;
        mon_on = 1'b1;
        // R2..R6: every code with distinct lanes
        for (int c = 0; c < 16; c++) drive(lane_pattern(8'h3C + 8'(c)), 5'(c), 1'b1);
        // R1: upper code bit set must not matter
        for (int c = 0; c < 16; c++) drive(lane_pattern(8'hA5 ^ 8'(c)), 5'(16 + c), 1'b1);
        // R7: single nonzero lane through identity and broadcast
        drive({16'hBEEF, {(VW-16){1'b0}}}, 5'd0, 1'b1);
        drive({16'hBEEF, {(VW-16){1'b0}}}, 5'd8, 1'b1);
        drive({{(VW-16){1'b0}}, 16'h1234}, 5'd15, 1'b1);
        // R9: idle cycles with changing inputs
        for (int i = 0; i < 4; i++) drive(lane_pattern(8'(i)), 5'(i + 9), 1'b0);
        // mixed random traffic with gaps
        for (int i = 0; i < 300; i++)
            drive({$urandom, $urandom, $urandom, $urandom}, 5'($urandom), 1'($urandom));
        drive('0, 5'd0, 1'b0);
        drive('0, 5'd0, 1'b0);
        check(exp_q.size() == 0, "R8 queue drained", VW'(exp_q.size()), '0);
        // R10: reset mid-stream clears output
        drive(lane_pattern(8'h77), 5'd4, 1'b1);
        @(negedge clk);
        mon_on = 1'b0;
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_vec == '0 && out_valid == 1'b0, "R10 reset clear", out_vec, '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule